// File: doc/BRIEF.md
# Timer Output Compare Unit with Master Channel

This block watches a free-running timer count supplied from outside and compares it, every clock, against a set of programmable 16-bit compare values, one per channel. When a channel's value equals the count, the channel latches a status flag, can request an interrupt, and changes its output pin in the way software selected for it. Channel index 0 acts as the master: when it fires it may drive any chosen subset of all output pins to chosen levels, which lets one compare event set up several pins at once. Software can also fire any channel's pin action at once through a force register, without waiting for the count.

New compare values are written into a holding register and only take effect on a cycle where the count does not equal them, so a value being updated never produces a stray match. Software reaches every register through a simple one-cycle write port; flags, interrupt requests and pins are visible as outputs.

Top module: `ocu_top`

## Requirements
- R1: When the active compare value of channel k equals `tcnt` in a cycle, `oc_flag[k]` is 1 from the following cycle on.
- R2: `oc_irq[k]` is 1 exactly when `oc_flag[k]` is 1 and bit k of the interrupt-enable register (write address 7) is 1.
- R3: Writing address 8 with bit k set clears `oc_flag[k]` at the next edge; a match of channel k in the same cycle wins and the flag stays set.
- R4: Channels 1 to 3 each act on their own pin when they fire, using a 2-bit code in the action register (address 4, channel k at bits [2k-1:2k-2]): 00 leaves the pin, 01 inverts it, 10 drives 0, 11 drives 1.
- R5: When channel 0 fires, every pin whose bit is set in the master mask register (address 5) takes the level of the same bit of the master data register (address 6); pins with a clear mask bit are left to their own channels.
- R6: If channel 0 and another channel act on the same pin in one cycle, the pin takes the master's level.
- R7: Writing address 9 with bit k set applies channel k's pin action at the next edge as if it had matched, and does not set `oc_flag[k]`.
- R8: A write of channel k's compare value (address k, for k from 0 to 3) goes to a holding register; it becomes active at the first later edge where `tcnt` differs from it, so it never matches while `tcnt` still equals it.
- R9: While `rst` is high, flags, pins, interrupt enables, action codes, master registers and compare values are all cleared; after reset the outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tcnt | input | 16 | Free-running timer count to compare against |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| oc_pin | output | 4 | Compare output pins |
| oc_flag | output | 4 | Per-channel match status flags |
| oc_irq | output | 4 | Per-channel interrupt requests |

## Verification
On every cycle the assertions check that a match is followed by its flag, that a flag only rises after a real match (so forcing never sets one), that a cleared flag without a match drops, that interrupt requests never appear without their flag, that a masked pin takes the master level after a master event, and that an active compare value only ever changes to something the count did not equal. The ordering of the holding-register transfer against a held count, the exact codes of the action field, and the priority of the master over a slave acting on the same pin are shown by the bench's scenarios, with a behavioural model compared against every output on every clock.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    // Pin action selected per slave channel
    typedef enum logic [1:0] {
        PA_KEEP   = 2'b00,
        PA_INVERT = 2'b01,
        PA_CLEAR  = 2'b10,
        PA_SET    = 2'b11
    } pin_act_e;

    // One channel's firing cause in a cycle
    typedef struct packed {
        logic hit;     // compare equal to counter
        logic kick;    // forced by software
    } fire_t;

    function automatic logic apply_act(input pin_act_e a, input logic cur);
        logic r;
        case (a)
            PA_INVERT: r = ~cur;
            PA_CLEAR:  r = 1'b0;
            PA_SET:    r = 1'b1;
            default:   r = cur;
        endcase
        return r;
    endfunction

    function automatic logic fired(input fire_t f);
        return f.hit | f.kick;
    endfunction

endpackage

// File: rtl/ocu_cmp_chan.sv
module ocu_cmp_chan #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tcnt,
    input  logic          ld_en,
    input  logic [TW-1:0] ld_val,
    output logic [TW-1:0] active,
    output logic          hit
);
    logic [TW-1:0] hold_q;
    logic          pend_q;
    logic          xfer;

    // Transfer only when the counter is away from the pending value
    assign xfer = pend_q && (hold_q != tcnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= 1'b0;
            active <= '0;
        end else begin
            if (xfer) begin
                active <= hold_q;
            end
            if (ld_en) begin
                hold_q <= ld_val;
                pend_q <= 1'b1;
            end else if (xfer) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign hit = (active == tcnt);

endmodule

// File: rtl/ocu_flag_bank.sv
module ocu_flag_bank #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    input  logic [NCH-1:0] ie_vec,
    output logic [NCH-1:0] flag,
    output logic [NCH-1:0] irq
);
    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag[k] <= 1'b0;
                end else if (set_vec[k]) begin
                    flag[k] <= 1'b1;
                end else if (clr_vec[k]) begin
                    flag[k] <= 1'b0;
                end
            end
            assign irq[k] = flag[k] & ie_vec[k];
        end
    endgenerate

endmodule

// File: rtl/ocu_pin_ctrl.sv
module ocu_pin_ctrl
    import ocu_pkg::*;
#(
    parameter int NCH = 4,
    localparam int AFW = 2 * (NCH - 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  fire_t          fire [NCH],
    input  logic [AFW-1:0] act_fields,
    input  logic [NCH-1:0] mmask,
    input  logic [NCH-1:0] mdata,
    output logic [NCH-1:0] pin
);
    logic [NCH-1:0] slave_nxt;
    logic [NCH-1:0] pin_nxt;
    logic           master_go;

    assign master_go = fired(fire[0]);

    // Pin 0 has no slave action of its own
    assign slave_nxt[0] = pin[0];

    genvar k;
    generate
        for (k = 1; k < NCH; k++) begin : g_slave
            pin_act_e a;
            assign a = pin_act_e'(act_fields[2*k-1 -: 2]);
            assign slave_nxt[k] = fired(fire[k]) ? apply_act(a, pin[k]) : pin[k];
        end
        for (k = 0; k < NCH; k++) begin : g_merge
            // Master wins over a slave on the same pin
            assign pin_nxt[k] = (master_go && mmask[k]) ? mdata[k] : slave_nxt[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= '0;
        end else begin
            pin <= pin_nxt;
        end
    end

endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 16,
    parameter int AW  = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [TW-1:0]  tcnt,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [TW-1:0]  wr_data,
    output logic [NCH-1:0] oc_pin,
    output logic [NCH-1:0] oc_flag,
    output logic [NCH-1:0] oc_irq
);
    localparam int AFW = 2 * (NCH - 1);
    localparam logic [AW-1:0] A_ACT   = AW'(NCH);
    localparam logic [AW-1:0] A_MMASK = AW'(NCH + 1);
    localparam logic [AW-1:0] A_MDATA = AW'(NCH + 2);
    localparam logic [AW-1:0] A_IE    = AW'(NCH + 3);
    localparam logic [AW-1:0] A_FCLR  = AW'(NCH + 4);
    localparam logic [AW-1:0] A_FORCE = AW'(NCH + 5);

    logic [AFW-1:0]   act_q;
    logic [NCH-1:0]   mmask_q;
    logic [NCH-1:0]   mdata_q;
    logic [NCH-1:0]   ie_q;
    logic [NCH-1:0]   match_vec;
    logic [NCH-1:0]   clr_vec;
    logic [NCH-1:0]   kick_vec;
    logic [NCH*TW-1:0] active_flat;
    logic             master_evt;
    fire_t            fire [NCH];

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            mmask_q <= '0;
            mdata_q <= '0;
            ie_q    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_ACT:   act_q   <= wr_data[AFW-1:0];
                A_MMASK: mmask_q <= wr_data[NCH-1:0];
                A_MDATA: mdata_q <= wr_data[NCH-1:0];
                A_IE:    ie_q    <= wr_data[NCH-1:0];
                default: ;
            endcase
        end
    end

    assign clr_vec  = (wr_en && wr_addr == A_FCLR)  ? wr_data[NCH-1:0] : '0;
    assign kick_vec = (wr_en && wr_addr == A_FORCE) ? wr_data[NCH-1:0] : '0;

    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_chan
            logic          ld;
            logic [TW-1:0] act_val;
            assign ld = wr_en && (wr_addr == AW'(k));
            ocu_cmp_chan #(.TW(TW)) u_chan (
                .clk    (clk),
                .rst    (rst),
                .tcnt   (tcnt),
                .ld_en  (ld),
                .ld_val (wr_data),
                .active (act_val),
                .hit    (match_vec[k])
            );
            assign active_flat[k*TW +: TW] = act_val;
            assign fire[k].hit  = match_vec[k];
            assign fire[k].kick = kick_vec[k];
        end
    endgenerate

    assign master_evt = fired(fire[0]);

    ocu_flag_bank #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (match_vec),
        .clr_vec (clr_vec),
        .ie_vec  (ie_q),
        .flag    (oc_flag),
        .irq     (oc_irq)
    );

    ocu_pin_ctrl #(.NCH(NCH)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .act_fields (act_q),
        .mmask      (mmask_q),
        .mdata      (mdata_q),
        .pin        (oc_pin)
    );

endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
    parameter int NCH = 4,
    parameter int TW  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [TW-1:0]   tcnt,
    input logic [NCH-1:0]  flag,
    input logic [NCH-1:0]  irq,
    input logic [NCH-1:0]  pin,
    input logic [NCH-1:0]  match_vec,
    input logic [NCH-1:0]  clr_vec,
    input logic            master_evt,
    input logic [NCH-1:0]  mmask,
    input logic [NCH-1:0]  mdata,
    input logic [NCH*TW-1:0] active
);
    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (pin == '0 && flag == '0));

    // R2
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (irq & ~flag) == '0);

    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_c
            // R1
            match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
                match_vec[k] |=> flag[k]);
            // R7
            flag_only_from_match_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(flag[k]) |-> $past(match_vec[k]));
            // R3
            clear_drops_flag_chk: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[k] && !match_vec[k]) |=> !flag[k]);
            // R6
            master_level_chk: assert property (@(posedge clk) disable iff (rst)
                (master_evt && mmask[k]) |=> (pin[k] == $past(mdata[k])));
            // R8
            safe_load_chk: assert property (@(posedge clk) disable iff (rst)
                !$stable(active[k*TW +: TW]) |-> (active[k*TW +: TW] != $past(tcnt)));
        end
    endgenerate

endmodule

bind ocu_top ocu_chk #(.NCH(NCH), .TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tcnt       (tcnt),
    .flag       (oc_flag),
    .irq        (oc_irq),
    .pin        (oc_pin),
    .match_vec  (match_vec),
    .clr_vec    (clr_vec),
    .master_evt (master_evt),
    .mmask      (mmask_q),
    .mdata      (mdata_q),
    .active     (active_flat)
);

// File: tb/ocu_top_tb.sv
`timescale 1ns/1ps
module ocu_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tcnt = 16'd100;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  oc_pin, oc_flag, oc_irq;

    int checks = 0;
    int errors = 0;
    int tick = 0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    ocu_top u_dut (
        .clk(clk), .rst(rst), .tcnt(tcnt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .oc_pin(oc_pin), .oc_flag(oc_flag), .oc_irq(oc_irq)
    );

    // Behavioural reference model
    logic [15:0] m_act [4];
    logic [15:0] m_hold [4];
    bit          m_pend [4];
    logic [3:0]  m_flag = '0, m_pin = '0, m_ie = '0, m_mask = '0, m_data = '0;
    logic [5:0]  m_codes = '0;

    always @(posedge clk) begin : model
        logic [3:0] hit, frc, np;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_act[i] = 0; m_hold[i] = 0; m_pend[i] = 0;
            end
            m_flag = 0; m_pin = 0; m_ie = 0; m_mask = 0; m_data = 0; m_codes = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                hit[i] = (m_act[i] == tcnt);
                frc[i] = wr_en && wr_addr == 4'd9 && wr_data[i];
            end
            np = m_pin;
            for (int i = 1; i < 4; i++) begin
                if (hit[i] || frc[i]) begin
                    case (m_codes[2*i-1 -: 2])
                        2'b01: np[i] = ~m_pin[i];
                        2'b10: np[i] = 1'b0;
                        2'b11: np[i] = 1'b1;
                        default: ;
                    endcase
                end
            end
            if (hit[0] || frc[0])
                for (int j = 0; j < 4; j++) if (m_mask[j]) np[j] = m_data[j];
            m_pin = np;
            for (int i = 0; i < 4; i++) begin
                if (hit[i]) m_flag[i] = 1'b1;
                else if (wr_en && wr_addr == 4'd8 && wr_data[i]) m_flag[i] = 1'b0;
                if (m_pend[i] && m_hold[i] != tcnt) begin
                    m_act[i] = m_hold[i]; m_pend[i] = 0;
                end
                if (wr_en && wr_addr == 4'(i)) begin
                    m_hold[i] = wr_data; m_pend[i] = 1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd4: m_codes = wr_data[5:0];
                    4'd5: m_mask  = wr_data[3:0];
                    4'd6: m_data  = wr_data[3:0];
                    4'd7: m_ie    = wr_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // Compare against model every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, "pin",  16'(oc_pin),  16'(m_pin));
            chk(cur_req, "flag", 16'(oc_flag), 16'(m_flag));
            chk("R2",    "irq",  16'(oc_irq),  16'(m_flag & m_ie));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        wr_en = 1'b0;
        tcnt = tcnt + 16'(tick);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run(3);
        rst = 1'b0;
        cyc();
        chk("R9", "reset pins",  16'(oc_pin),  16'h0);
        chk("R9", "reset flags", 16'(oc_flag), 16'h0);
        chk("R9", "reset irq",   16'(oc_irq),  16'h0);

        // Slave actions: ch1 invert, ch2 drive low, ch3 drive high
        cur_req = "R4";
        wr(4'd4, 16'h0039);
        wr(4'd1, 16'd110);
        wr(4'd2, 16'd120);
        wr(4'd3, 16'd130);
        tick = 1; run(40); tick = 0;
        chk("R4", "slave pin actions", 16'(oc_pin), 16'hA);
        chk("R1", "flags after matches", 16'(oc_flag), 16'hE);

        cur_req = "R2";
        wr(4'd7, 16'h0002);
        chk("R2", "irq enabled ch1", 16'(oc_irq), 16'h2);

        cur_req = "R3";
        wr(4'd8, 16'h0006);
        chk("R3", "partial clear", 16'(oc_flag), 16'h8);
        chk("R2", "irq after clear", 16'(oc_irq), 16'h0);
        wr(4'd8, 16'h000F);
        chk("R3", "full clear", 16'(oc_flag), 16'h0);

        // Master drives pins 0 and 3
        cur_req = "R5";
        wr(4'd5, 16'h0009);
        wr(4'd6, 16'h0001);
        wr(4'd0, 16'd150);
        tick = 1; run(20); tick = 0;
        chk("R5", "master masked pins", 16'(oc_pin), 16'h3);
        chk("R1", "master flag", 16'(oc_flag), 16'h1);

        // Master and ch1 on same pin, same cycle
        cur_req = "R6";
        wr(4'd4, 16'h003B);
        wr(4'd5, 16'h0002);
        wr(4'd6, 16'h0000);
        wr(4'd0, 16'd170);
        wr(4'd1, 16'd170);
        tick = 1; run(15); tick = 0;
        chk("R6", "master over slave", 16'(oc_pin), 16'h1);
        chk("R1", "both flags", 16'(oc_flag), 16'h3);

        cur_req = "R7";
        wr(4'd8, 16'h000F);
        wr(4'd9, 16'h0008);
        chk("R7", "forced pin", 16'(oc_pin), 16'h9);
        chk("R7", "forced no flag", 16'(oc_flag), 16'h0);

        // Guarded compare load with counter held equal
        cur_req = "R8";
        tcnt = 16'd200;
        wr(4'd1, 16'd200);
        run(4);
        chk("R8", "no match while held equal", 16'(oc_flag), 16'h0);
        tcnt = 16'd201;
        run(2);
        tcnt = 16'd200;
        run(2);
        chk("R8", "match after transfer", 16'(oc_flag), 16'h2);

        // Free running mix against the model
        cur_req = "R1";
        tcnt = 16'd300;
        wr(4'd8, 16'h000F);
        wr(4'd7, 16'h000F);
        wr(4'd4, 16'h0015);
        wr(4'd5, 16'h000C);
        wr(4'd6, 16'h0004);
        tick = 1;
        for (int r = 0; r < 8; r++) begin
            wr(4'(r % 4), 16'(310 + 7 * r));
            run(9);
            if (r % 3 == 0) wr(4'd8, 16'h0005);
            if (r % 4 == 1) wr(4'd9, 16'(r));
        end
        run(20);
        tick = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule